// File: doc/BRIEF.md
# Command Response Parser

This block sits behind a serial-bus master and judges the reply that the master clocks in after a command has gone out. At the start of each transaction the controller gives it the opcode it just issued and whether CRC trailers are in use. The block then walks the incoming reply one byte at a time:

- For the three control opcodes it first discards one leading byte.
- It checks that the opcode is echoed back and that the status byte is clear.
- For read opcodes it hunts for a data header, which is a byte whose upper nibble is all ones. The hunt stops after a bounded number of bytes.
- For word reads it collects the four-byte read word, then swallows the CRC trailer when CRC is enabled.

It ends each transaction with a one-cycle completion pulse and a result code:

- ok, when the reply is well formed;
- fail, when the reply is malformed or the stream stopped early;
- reset, when no data header turned up within the budget, so the link has to be resynchronised.

For block reads the parser finishes on the data header. The block data itself is handled downstream.

Top module: `spi_rsp_parser`

## Requirements
- R1: After reset `done` is 0, `result` is 2'b00 (none) and `rd_word` is 0.
- R2: For the control opcodes 0xCF, 0xC5 and 0xC6, the first reply byte is discarded without being examined. The second byte is treated as the echo.
- R3: The echo byte must equal the issued opcode. Otherwise the transaction ends with fail (2'b10) on that byte.
- R4: The byte after the echo is a status byte. A non-zero status ends with fail. For an opcode that is not a read, a zero status ends with ok (2'b01) on that byte.
- R5: For the read opcodes 0xC4, 0xCA, 0xC2 and 0xC8, the bytes after a zero status are scanned until one has bits [7:4] equal to 4'hF. For the block reads 0xC2 and 0xC8 the transaction ends ok on that header byte.
- R6: If HUNT_LIMIT (default 100) consecutive scanned bytes lack the header nibble, the transaction ends with reset (2'b11) on the last of them. A header arriving as the HUNT_LIMIT-th scanned byte still succeeds.
- R7: For the word reads 0xC4 and 0xCA, exactly four bytes follow the header. The first received lands in `rd_word[7:0]` and the last in `rd_word[31:24]`. With CRC disabled the transaction ends ok on the fourth byte.
- R8: With CRC enabled, two further bytes after the read word are consumed without any check, and the transaction ends ok on the second of them.
- R9: `rx_end` during a transaction ends it with fail. The exception is a byte presented in the same cycle that itself completes the transaction; then that byte's outcome wins.
- R10: `done` is high for exactly one cycle, in the cycle after the clock edge that took the deciding byte. `result` and `rd_word` hold their values until a later transaction changes them.
- R11: `start` while a transaction is in progress is ignored. Bytes and `rx_end` arriving while idle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (accepted only when idle) |
| op | input | 8 | Opcode that was issued, sampled with `start` |
| crc_en | input | 1 | CRC trailer present on word reads, sampled with `start` |
| rx_valid | input | 1 | `rx_byte` carries a received byte this cycle |
| rx_byte | input | 8 | Received reply byte |
| rx_end | input | 1 | The master has no more bytes for this reply |
| done | output | 1 | One-cycle transaction completion pulse |
| result | output | 2 | 00 none, 01 ok, 10 fail, 11 reset required |
| rd_word | output | 32 | Captured read word, first byte in the low bits |

## Verification
The byte-consumption path and the end-of-stream abort can both act in one cycle. This is provoked by raising `rx_end` together with a byte, in two cases:

- The byte is the last word byte of a CRC-less read. Here the byte completes the transaction, so ok is expected with the full word.
- The byte is a middle word byte. Here fail is expected on that same cycle.

The reference model in the bench computes, from the byte list and the index of the end marker, which byte index decides the outcome. Every cycle's `done` is compared against that index.

// File: rtl/spi_rsp_pkg.sv
package spi_rsp_pkg;

  typedef enum logic [1:0] {
    RES_NONE  = 2'b00,
    RES_OK    = 2'b01,
    RES_FAIL  = 2'b10,
    RES_RESET = 2'b11
  } rsp_result_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SKIP,
    PH_ECHO,
    PH_STATUS,
    PH_HUNT,
    PH_WORD,
    PH_CRC
  } rsp_phase_e;

  // Control opcodes carry one throw-away byte ahead of the echo.
  function automatic logic op_is_ctrl(input logic [7:0] o);
    return (o == 8'hCF) || (o == 8'hC5) || (o == 8'hC6);
  endfunction

  // Opcodes that return a data header after the status byte.
  function automatic logic op_is_read(input logic [7:0] o);
    return (o == 8'hC4) || (o == 8'hCA) || (o == 8'hC2) || (o == 8'hC8);
  endfunction

  // Reads that return a single word after the header.
  function automatic logic op_is_word_read(input logic [7:0] o);
    return (o == 8'hC4) || (o == 8'hCA);
  endfunction

  function automatic logic byte_is_header(input logic [7:0] b);
    return b[7:4] == 4'hF;
  endfunction

endpackage

// File: rtl/rsp_hunt_ctr.sv
module rsp_hunt_ctr #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic exhausted
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign exhausted = step && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (step)   cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/rsp_word_asm.sv
module rsp_word_asm #(
  parameter int NBYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  load,
  input  logic [7:0]            din,
  output logic [NBYTES*8-1:0]   word,
  output logic                  last
);
  localparam int IW = $clog2(NBYTES + 1);

  logic [IW-1:0] idx;

  assign last = load && (idx == IW'(NBYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      word <= '0;
    end else if (clear) begin
      idx <= '0;
    end else if (load) begin
      word[idx*8 +: 8] <= din;
      idx <= idx + IW'(1);
    end
  end
endmodule

// File: rtl/spi_rsp_parser.sv
module spi_rsp_parser
  import spi_rsp_pkg::*;
#(
  parameter int HUNT_LIMIT = 100,
  parameter int WORD_BYTES = 4,
  parameter int CRC_BYTES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [7:0]              op,
  input  logic                    crc_en,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_byte,
  input  logic                    rx_end,
  output logic                    done,
  output logic [1:0]              result,
  output logic [WORD_BYTES*8-1:0] rd_word
);
  localparam int CCW = $clog2(CRC_BYTES + 1);

  rsp_phase_e  phase, phase_nxt;
  logic [7:0]  op_q;
  logic        crc_q;
  logic [CCW-1:0] crc_cnt;

  // Named internal events.
  logic        busy;
  logic        accept_start;
  logic        take;
  logic        fin;
  rsp_result_e fin_res;
  logic        hunt_step;
  logic        hunt_exhaust;
  logic        word_load;
  logic        word_last;

  assign busy         = (phase != PH_IDLE);
  assign accept_start = start && !busy;
  assign take         = rx_valid && busy;

  rsp_hunt_ctr #(.LIMIT(HUNT_LIMIT)) u_hunt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept_start),
    .step      (hunt_step),
    .exhausted (hunt_exhaust)
  );

  rsp_word_asm #(.NBYTES(WORD_BYTES)) u_word (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept_start),
    .load  (word_load),
    .din   (rx_byte),
    .word  (rd_word),
    .last  (word_last)
  );

  always_comb begin
    phase_nxt = phase;
    fin       = 1'b0;
    fin_res   = RES_NONE;
    hunt_step = 1'b0;
    word_load = 1'b0;
    unique case (phase)
      PH_IDLE: if (start) phase_nxt = op_is_ctrl(op) ? PH_SKIP : PH_ECHO;
      PH_SKIP: if (take) phase_nxt = PH_ECHO;
      PH_ECHO: if (take) begin
        if (rx_byte != op_q) begin fin = 1'b1; fin_res = RES_FAIL; end
        else phase_nxt = PH_STATUS;
      end
      PH_STATUS: if (take) begin
        if (rx_byte != 8'h00)       begin fin = 1'b1; fin_res = RES_FAIL; end
        else if (!op_is_read(op_q)) begin fin = 1'b1; fin_res = RES_OK;   end
        else phase_nxt = PH_HUNT;
      end
      PH_HUNT: if (take) begin
        if (byte_is_header(rx_byte)) begin
          if (op_is_word_read(op_q)) phase_nxt = PH_WORD;
          else begin fin = 1'b1; fin_res = RES_OK; end
        end else begin
          hunt_step = 1'b1;
          if (hunt_exhaust) begin fin = 1'b1; fin_res = RES_RESET; end
        end
      end
      PH_WORD: if (take) begin
        word_load = 1'b1;
        if (word_last) begin
          if (crc_q && (CRC_BYTES > 0)) phase_nxt = PH_CRC;
          else begin fin = 1'b1; fin_res = RES_OK; end
        end
      end
      PH_CRC: if (take && (crc_cnt == CCW'(CRC_BYTES - 1))) begin
        fin = 1'b1; fin_res = RES_OK;
      end
      default: phase_nxt = PH_IDLE;
    endcase
    // A byte that completes the transaction wins over end of stream.
    if (busy && rx_end && !fin) begin
      fin     = 1'b1;
      fin_res = RES_FAIL;
    end
    if (fin) phase_nxt = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      op_q    <= '0;
      crc_q   <= 1'b0;
      crc_cnt <= '0;
      done    <= 1'b0;
      result  <= RES_NONE;
    end else begin
      phase <= phase_nxt;
      done  <= fin;
      if (fin) result <= fin_res;
      if (accept_start) begin
        op_q    <= op;
        crc_q   <= crc_en;
        crc_cnt <= '0;
      end else if (take && phase == PH_CRC) begin
        crc_cnt <= crc_cnt + CCW'(1);
      end
    end
  end
endmodule

// File: rtl/spi_rsp_parser_chk.sv
module spi_rsp_parser_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       rx_end,
  input logic       hunt_exhaust,
  input logic       done,
  input logic [1:0] result,
  input logic [31:0] rd_word
);
  // R10: a completion always carries a real result code
  p_done_has_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result != 2'b00));

  // R10: completion returns the parser to idle
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10: no completion can come out of an idle cycle
  p_idle_no_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !done);

  // R9: end of stream during a transaction always terminates it
  p_end_terminates_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rx_end) |=> done);

  // R6: running out of hunt budget gives the reset outcome
  p_exhaust_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_exhaust |=> (done && result == 2'b11));

  // R10, R11: the read word is left alone while idle
  p_word_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(rd_word));
endmodule

bind spi_rsp_parser spi_rsp_parser_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .rx_end       (rx_end),
  .hunt_exhaust (hunt_exhaust),
  .done         (done),
  .result       (result),
  .rd_word      (rd_word)
);

// File: tb/test_spi_rsp_parser.sv
module test_spi_rsp_parser;
  localparam int LIM = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  op = 8'h00;
  logic        crc_en = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        rx_end = 1'b0;
  logic        done;
  logic [1:0]  result;
  logic [31:0] rd_word;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  spi_rsp_parser i_spi_rsp_parser (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .crc_en(crc_en),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_end(rx_end),
    .done(done), .result(result), .rd_word(rd_word)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: walk the byte list, report deciding index.
  function automatic bit avail(input int idx, input int n, input int endi);
    return (idx <= endi) && (idx < n);
  endfunction

  function automatic void model(input logic [7:0] o, input bit crc,
                                input logic [7:0] q[$], input int endi,
                                output int k, output int res, output logic [31:0] w);
    int n = q.size();
    int p;
    int miss;
    bit ctrl  = (o == 8'hCF || o == 8'hC5 || o == 8'hC6);
    bit rd    = (o == 8'hC4 || o == 8'hCA || o == 8'hC2 || o == 8'hC8);
    bit wrd   = (o == 8'hC4 || o == 8'hCA);
    w = 32'h0;
    p = ctrl ? 1 : 0;
    if (!avail(p, n, endi)) begin k = endi; res = 2; return; end
    if (q[p] != o) begin k = p; res = 2; return; end
    p++;
    if (!avail(p, n, endi)) begin k = endi; res = 2; return; end
    if (q[p] != 8'h00) begin k = p; res = 2; return; end
    if (!rd) begin k = p; res = 1; return; end
    miss = 0;
    forever begin
      p++;
      if (!avail(p, n, endi)) begin k = endi; res = 2; return; end
      if (q[p] >= 8'hF0) break;
      miss++;
      if (miss == LIM) begin k = p; res = 3; return; end
    end
    if (!wrd) begin k = p; res = 1; return; end
    for (int j = 0; j < 4; j++) begin
      p++;
      if (!avail(p, n, endi)) begin k = endi; res = 2; return; end
      w = w | (32'(q[p]) << (8 * j));
    end
    if (crc) begin
      for (int j = 0; j < 2; j++) begin
        p++;
        if (!avail(p, n, endi)) begin k = endi; res = 2; return; end
      end
    end
    k = p; res = 1;
  endfunction

  task automatic run(input string req, input logic [7:0] o, input bit crc,
                     input logic [7:0] q[$], input int endi,
                     input bit gap, input bit poke);
    int k, res, last;
    logic [31:0] w;
    bit wrd = (o == 8'hC4 || o == 8'hCA);
    model(o, crc, q, endi, k, res, w);
    @(negedge clk);
    start = 1'b1; op = o; crc_en = crc;
    @(negedge clk);
    start = 1'b0; crc_en = 1'b0;
    chk(done == 1'b0, req, "done at start", 32'(done), 32'h0);
    last = (q.size() > endi + 1) ? q.size() : endi + 1;
    for (int i = 0; i < last; i++) begin
      rx_valid = (i < q.size());
      rx_byte  = (i < q.size()) ? q[i] : 8'h00;
      rx_end   = (i == endi);
      if (poke && i == 1) begin start = 1'b1; op = 8'hC9; end
      @(negedge clk);
      rx_valid = 1'b0; rx_end = 1'b0; start = 1'b0; op = o;
      chk(done == (i == k), req, $sformatf("done after byte %0d", i),
          32'(done), 32'(i == k));
      if (i == k) begin
        chk(result == 2'(res), req, "result code", 32'(result), 32'(res));
        if (res == 1 && wrd)
          chk(rd_word == w, req, "read word", rd_word, w);
      end
      if (gap) begin
        @(negedge clk);
        chk(done == 1'b0, req, "done in gap", 32'(done), 32'h0);
      end
    end
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(done == 1'b0, "R10", "done single pulse", 32'(done), 32'h0);
    end
    chk(result == 2'(res), "R10", "result held", 32'(result), 32'(res));
    if (res == 1 && wrd)
      chk(rd_word == w, "R10", "word held", rd_word, w);
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] q[$];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(done == 1'b0, "R1", "done", 32'(done), 32'h0);
    chk(result == 2'b00, "R1", "result", 32'(result), 32'h0);
    chk(rd_word == 32'h0, "R1", "rd_word", rd_word, 32'h0);

    // R5 R7 R8 R11: single read with CRC trailer, stray start mid-way
    q = '{8'hCA, 8'h00, 8'h12, 8'h34, 8'hF0, 8'h11, 8'h22, 8'h33, 8'h44, 8'hAA, 8'hBB};
    run("R8", 8'hCA, 1'b1, q, q.size(), 1'b0, 1'b1);
    // R7: internal read, CRC off, gaps between bytes
    q = '{8'hC4, 8'h00, 8'hF7, 8'hDE, 8'hAD, 8'hBE, 8'hEF};
    run("R7", 8'hC4, 1'b0, q, q.size(), 1'b1, 1'b0);
    // R2: control opcodes discard a first byte
    q = '{8'h55, 8'hCF, 8'h00};
    run("R2", 8'hCF, 1'b0, q, q.size(), 1'b0, 1'b0);
    q = '{8'h00, 8'hC5, 8'h00};
    run("R2", 8'hC5, 1'b0, q, q.size(), 1'b0, 1'b0);
    q = '{8'hC6, 8'hC6, 8'h00};
    run("R2", 8'hC6, 1'b0, q, q.size(), 1'b0, 1'b0);
    // R3: echo mismatch
    q = '{8'hC8, 8'h00};
    run("R3", 8'hC9, 1'b0, q, q.size(), 1'b0, 1'b0);
    // R4: bad status, then good write; trailing bytes ignored (R11)
    q = '{8'hC3, 8'h01};
    run("R4", 8'hC3, 1'b0, q, q.size(), 1'b0, 1'b0);
    q = '{8'hC9, 8'h00, 8'hC9, 8'h00, 8'hF0};
    run("R11", 8'hC9, 1'b0, q, q.size(), 1'b0, 1'b0);
    // R5: block read finishes on header
    q = '{8'hC8, 8'h00, 8'h01, 8'hF5, 8'h99, 8'h98};
    run("R5", 8'hC8, 1'b1, q, q.size(), 1'b0, 1'b0);
    // R6: budget exhausted
    q = '{8'hC2, 8'h00};
    for (int i = 0; i < LIM + 3; i++) q.push_back(8'(i % 16) << 0);
    run("R6", 8'hC2, 1'b0, q, q.size(), 1'b0, 1'b0);
    // R6: header as the last allowed byte
    q = '{8'hC2, 8'h00};
    for (int i = 0; i < LIM - 1; i++) q.push_back(8'hE7);
    q.push_back(8'hF1);
    run("R6", 8'hC2, 1'b0, q, q.size(), 1'b0, 1'b0);
    // R9: end in the middle of the word
    q = '{8'hCA, 8'h00, 8'hF0, 8'h11, 8'h22, 8'h33, 8'h44};
    run("R9", 8'hCA, 1'b0, q, 3, 1'b0, 1'b0);
    // R9: end together with the completing byte
    q = '{8'hC4, 8'h00, 8'hF0, 8'h01, 8'h02, 8'h03, 8'h04};
    run("R9", 8'hC4, 1'b0, q, 6, 1'b0, 1'b0);
    // R9: end after too few bytes
    q = '{8'hCA, 8'h00};
    run("R9", 8'hCA, 1'b0, q, 2, 1'b0, 1'b0);
    // R9: end with crc byte pending
    q = '{8'hCA, 8'h00, 8'hF0, 8'h01, 8'h02, 8'h03, 8'h04, 8'h77};
    run("R9", 8'hCA, 1'b1, q, 8, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule